// File: doc/BRIEF.md
# Triple Dot Product Matrix Multiplier

This block multiplies a stream of three-element sample vectors by a stored 3x3 coefficient matrix. On every clock it takes three signed integer samples on ports `a`, `b` and `c`. Five edges later, counting the edge that captured them, it delivers three signed integer results on `x`, `y` and `z`. Each result is the dot product of the sample vector with one column of the matrix. The block suits colour-space conversion and 3-D coordinate transforms, where one full transform is needed per pixel per clock.

The nine coefficients are signed fractions held in a register bank inside the block. A column of three is loaded in one clock from ports `ka`, `kb` and `kc`. A 2-bit select picks the column, and its zero code leaves the whole bank unchanged. The exact sum of products is rounded by adding half an output LSB and is then cut back to the sample format. The numeric formats allow only unity gain, so a sum that falls outside the output range wraps in two's complement.

Top module: `mmx_triple_dot`

## Requirements
- R1: Samples `a`, `b`, `c` and results `x`, `y`, `z` are 12-bit two's complement integers. Coefficients are 10-bit two's complement fractions: the sign bit has weight -2^0 and bits 8..0 have weights 2^-1 down to 2^-9, so code 0x200 means -1.0 and code 0x100 means +0.5.
- R2: Column j (j = 1, 2, 3) holds three coefficients, one for each of `a`, `b` and `c`. Result `x` uses column 1, `y` uses column 2 and `z` uses column 3, and each result equals a·K(a,j) + b·K(b,j) + c·K(c,j).
- R3: When `ksel` = 00 at a rising edge, none of the nine coefficients changes at that edge, whatever is on `ka`, `kb` and `kc`.
- R4: When `ksel` = 01, 10 or 11 at a rising edge, the values on `ka`, `kb` and `kc` are written at that edge into the a-, b- and c-coefficients of column 1, 2 or 3 respectively.
- R5: A column write leaves the other two columns unchanged.
- R6: Samples captured at edge n produce the results visible after edge n+4. A new result triple appears after every edge.
- R7: The exact sum S, which has 9 fractional bits, is rounded to floor((S + 2^8) / 2^9). Exact halves therefore round toward plus infinity.
- R8: If the rounded value falls outside -2048..2047, the output is its low 12 bits (two's complement wrap), with no saturation.
- R9: A synchronous active-high `rst` clears all nine coefficients and every pipeline register. The outputs read zero after the first edge with `rst` high.
- R10: Samples captured at the same edge as a column write, or at any later edge, use the new coefficients. Samples captured at earlier edges use the old coefficients.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a | input | 12 | Sample, first vector element |
| b | input | 12 | Sample, second vector element |
| c | input | 12 | Sample, third vector element |
| ka | input | 10 | Coefficient for `a` in the selected column |
| kb | input | 10 | Coefficient for `b` in the selected column |
| kc | input | 10 | Coefficient for `c` in the selected column |
| ksel | input | 2 | Column write select: 00 hold, 01/10/11 write column 1/2/3 |
| x | output | 12 | Result using column 1 |
| y | output | 12 | Result using column 2 |
| z | output | 12 | Result using column 3 |

## Verification
The assertions check, on every cycle, the behaviour of the coefficient bank: the hold code keeps the bank unchanged, a write lands in the selected column with the port values, and the other columns stay as they were. They also check that reset clears the bank and the outputs, and that an all-zero sample vector gives all-zero results exactly five edges later. Only the bench scenarios can show the arithmetic itself. These cover exact products, rounding of halves in both signs, two's complement wrap on overflow, and the edge on which a new coefficient starts to apply to a moving data stream. A bench model with the same five-edge delay checks them across a full sweep of sample values.

// File: rtl/mmx_pkg.sv
package mmx_pkg;
   localparam int unsigned NTERM = 3;

   typedef enum logic [1:0] {
      KSEL_HOLD = 2'd0,
      KSEL_COL1 = 2'd1,
      KSEL_COL2 = 2'd2,
      KSEL_COL3 = 2'd3
   } ksel_e;
endpackage

// File: rtl/mmx_coef_bank.sv
module mmx_coef_bank
   import mmx_pkg::*;
#(
   parameter int KW = 10,
   parameter int NT = NTERM
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [1:0]                    ksel,
   input  logic [NT-1:0][KW-1:0]         k_in,
   output logic [NT-1:0][NT-1:0][KW-1:0] bank_q
);
   generate
      if (KW < 2) begin : g_bad_kw
         $error("coefficient width must be at least 2");
      end
      if (NT != 3) begin : g_bad_nt
         $error("the select code covers exactly three columns");
      end
   endgenerate

   generate
      for (genvar col = 0; col < NT; col++) begin : g_col
         always_ff @(posedge clk) begin
            if (rst)
               bank_q[col] <= '0;
            else if (ksel == 2'(col + 1))
               bank_q[col] <= k_in;
         end

         // R4: a selected column takes the port values
         p_write_r4: assert property (@(posedge clk) disable iff (rst)
            (ksel == 2'(col + 1)) |=> (bank_q[col] == $past(k_in)));

         // R5: a write aimed elsewhere leaves this column alone
         p_others_r5: assert property (@(posedge clk) disable iff (rst)
            (ksel != KSEL_HOLD && ksel != 2'(col + 1)) |=> $stable(bank_q[col]));
      end
   endgenerate

   // R3: hold code keeps the whole bank
   p_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (ksel == KSEL_HOLD) |=> $stable(bank_q));

   // R9: reset empties the bank
   p_bank_clear_r9: assert property (@(posedge clk)
      rst |=> (bank_q == '0));
endmodule

// File: rtl/mmx_dot_lane.sv
module mmx_dot_lane
   import mmx_pkg::*;
#(
   parameter int DW = 12,
   parameter int KW = 10,
   parameter int NT = NTERM
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [NT-1:0][DW-1:0] d,
   input  logic [NT-1:0][KW-1:0] k,
   output logic [DW-1:0]         res
);
   localparam int PW = DW + KW;
   localparam int SW = PW + $clog2(NT);
   localparam int FR = KW - 1;
   localparam logic signed [SW-1:0] HALF = SW'(1) <<< (FR - 1);

   generate
      if (DW < 2 || KW < 2) begin : g_bad_width
         $error("data and coefficient widths must be at least 2");
      end
   endgenerate

   logic signed [PW-1:0] prod_q [NT];
   logic signed [SW-1:0] sum_c;
   logic signed [SW-1:0] sum_q;
   logic signed [SW-1:0] bias_q;

   // stage 2: one multiplier per term
   generate
      for (genvar i = 0; i < NT; i++) begin : g_mul
         logic signed [PW-1:0] d_ext;
         logic signed [PW-1:0] k_ext;
         assign d_ext = PW'($signed(d[i]));
         assign k_ext = PW'($signed(k[i]));
         always_ff @(posedge clk) begin
            if (rst) prod_q[i] <= '0;
            else     prod_q[i] <= d_ext * k_ext;
         end
      end
   endgenerate

   // stage 3: full-precision sum
   always_comb begin
      sum_c = '0;
      for (int i = 0; i < NT; i++)
         sum_c = sum_c + SW'(prod_q[i]);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sum_q  <= '0;
         bias_q <= '0;
         res    <= '0;
      end else begin
         sum_q  <= sum_c;
         bias_q <= sum_q + HALF;      // stage 4: half-LSB bias
         res    <= bias_q[FR +: DW];  // stage 5: drop fraction, wrap high bits
      end
   end

   logic unused_bits;
   assign unused_bits = ^{bias_q[FR-1:0], bias_q[SW-1:FR+DW]};
endmodule

// File: rtl/mmx_triple_dot.sv
module mmx_triple_dot
   import mmx_pkg::*;
#(
   parameter int DW = 12,
   parameter int KW = 10
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic [DW-1:0] c,
   input  logic [KW-1:0] ka,
   input  logic [KW-1:0] kb,
   input  logic [KW-1:0] kc,
   input  logic [1:0]    ksel,
   output logic [DW-1:0] x,
   output logic [DW-1:0] y,
   output logic [DW-1:0] z
);
   localparam int NT = NTERM;

   logic [NT-1:0][DW-1:0]         d_q;
   logic [NT-1:0][KW-1:0]         k_in;
   logic [NT-1:0][NT-1:0][KW-1:0] bank;
   logic [NT-1:0][DW-1:0]         res;

   assign k_in[0] = ka;
   assign k_in[1] = kb;
   assign k_in[2] = kc;

   // stage 1: sample capture
   always_ff @(posedge clk) begin
      if (rst) d_q <= '0;
      else begin
         d_q[0] <= a;
         d_q[1] <= b;
         d_q[2] <= c;
      end
   end

   mmx_coef_bank #(.KW(KW), .NT(NT)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .ksel   (ksel),
      .k_in   (k_in),
      .bank_q (bank)
   );

   generate
      for (genvar col = 0; col < NT; col++) begin : g_lane
         mmx_dot_lane #(.DW(DW), .KW(KW), .NT(NT)) u_lane (
            .clk (clk),
            .rst (rst),
            .d   (d_q),
            .k   (bank[col]),
            .res (res[col])
         );
      end
   endgenerate

   assign x = res[0];
   assign y = res[1];
   assign z = res[2];

   // edges since reset, saturating, for the latency check
   logic [2:0] age_q;
   always_ff @(posedge clk) begin
      if (rst)                age_q <= '0;
      else if (age_q != 3'd7) age_q <= age_q + 3'd1;
   end

   // R9: outputs read zero after a reset edge
   p_out_clear_r9: assert property (@(posedge clk)
      rst |=> (x == '0 && y == '0 && z == '0));

   // R6: zero vector at the ports shows up as zero results five edges on
   p_zero_latency_r6: assert property (@(posedge clk) disable iff (rst)
      (age_q >= 3'd6 && $past(a == '0 && b == '0 && c == '0, 5))
      |-> (x == '0 && y == '0 && z == '0));
endmodule

// File: tb/tb_mmx_triple_dot.sv
module tb_mmx_triple_dot;
   localparam int DW = 12;
   localparam int KW = 10;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst;
   logic [DW-1:0] a, b, c;
   logic [KW-1:0] ka, kb, kc;
   logic [1:0]    ksel;
   logic [DW-1:0] x, y, z;

   mmx_triple_dot #(.DW(DW), .KW(KW)) dut (
      .clk(clk), .rst(rst), .a(a), .b(b), .c(c),
      .ka(ka), .kb(kb), .kc(kc), .ksel(ksel),
      .x(x), .y(y), .z(z)
   );

   int          checks = 0;
   int          fails  = 0;
   string       req    = "R9";
   int          mk [3][3];   // [column][term]
   int          pipe [5][3]; // expected results, index = edges since capture
   bit          done   = 1'b0;
   int unsigned seed   = 32'h2545F491;

   function automatic int sx(input int v, input int w);
      int m;
      m = v & ((1 << w) - 1);
      if (m >= (1 << (w - 1))) m = m - (1 << w);
      return m;
   endfunction

   // R7/R8: half-LSB round, then keep 12 bits
   function automatic int rnd12(input longint s);
      longint t;
      t = (s + 64'sd256) >>> 9;
      return sx(int'(t), 12);
   endfunction

   function automatic int nextr();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return int'(seed);
   endfunction

   task automatic chk(input string tag, input string nm, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, nm, act, exp, $time);
      end
   endtask

   task automatic cyc(input int av, input int bv, input int cv,
                      input int s, input int kav, input int kbv, input int kcv);
      int e [3];
      a    = av[DW-1:0];
      b    = bv[DW-1:0];
      c    = cv[DW-1:0];
      ka   = kav[KW-1:0];
      kb   = kbv[KW-1:0];
      kc   = kcv[KW-1:0];
      ksel = s[1:0];
      @(posedge clk);
      if (rst) begin
         foreach (mk[i, j]) mk[i][j] = 0;
         foreach (pipe[i, j]) pipe[i][j] = 0;
      end else begin
         if (s != 0) begin
            mk[s-1][0] = sx(kav, KW);
            mk[s-1][1] = sx(kbv, KW);
            mk[s-1][2] = sx(kcv, KW);
         end
         for (int j = 0; j < 3; j++)
            e[j] = rnd12(longint'(sx(av, DW)) * mk[j][0] +
                         longint'(sx(bv, DW)) * mk[j][1] +
                         longint'(sx(cv, DW)) * mk[j][2]);
         for (int p = 4; p > 0; p--)
            for (int j = 0; j < 3; j++) pipe[p][j] = pipe[p-1][j];
         for (int j = 0; j < 3; j++) pipe[0][j] = e[j];
      end
      @(negedge clk);
      chk(req, "x", sx(int'(x), DW), pipe[4][0]);
      chk(req, "y", sx(int'(y), DW), pipe[4][1]);
      chk(req, "z", sx(int'(z), DW), pipe[4][2]);
   endtask

   task automatic rand_cyc(input int s);
      cyc(nextr(), nextr(), nextr(), s, nextr(), nextr(), nextr());
   endtask

   initial begin
      #(20ns * 150000);
      if (!done) begin
         fails++;
         $display("FAIL R6 watchdog: actual no completion expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      foreach (mk[i, j]) mk[i][j] = 0;
      foreach (pipe[i, j]) pipe[i][j] = 0;
      rst = 1'b1;
      a = '0; b = '0; c = '0; ka = '0; kb = '0; kc = '0; ksel = '0;
      @(negedge clk);

      // R9: reset state, with stray write attempts that must not land
      req = "R9";
      repeat (4) cyc(100, -7, 33, 1, 200, -300, 5);
      rst = 1'b0;

      // R4: one column per select code, -1.0 on the diagonal
      req = "R4";
      cyc(0, 0, 0, 1, 12'h200, 0, 0);
      cyc(0, 0, 0, 2, 0, 12'h200, 0);
      cyc(0, 0, 0, 3, 0, 0, 12'h200);

      // R2/R6/R8: full sample sweep through the negating diagonal
      req = "R2/R6/R8";
      for (int i = 0; i < 4096; i++)
         cyc(i - 2048, ((i * 7) % 4096) - 2048, 2047 - i, 0, 0, 0, 0);
      repeat (5) cyc(0, 0, 0, 0, 0, 0, 0);

      // R1/R7: fractional weights including +0.5, 1/512 and -1/512
      req = "R1/R7";
      cyc(0, 0, 0, 1, 256, 1, -1);
      cyc(0, 0, 0, 2, -256, 511, 3);
      cyc(0, 0, 0, 3, -512, -1, 255);
      for (int i = 0; i < 4096; i++)
         cyc(i - 2048, ((i * 13) % 4096) - 2048, ((i * 5 + 100) % 4096) - 2048, 0, 0, 0, 0);
      // exact halves in both signs: 0.5*3 -> 2, 0.5*-3 -> -1
      cyc(0, 0, 0, 1, 256, 0, 0);
      cyc(3, 0, 0, 0, 0, 0, 0);
      cyc(-3, 0, 0, 0, 0, 0, 0);
      repeat (4) cyc(0, 0, 0, 0, 0, 0, 0);
      chk("R7", "x half neg", sx(int'(x), DW), -1);
      @(negedge clk);
      // x updates once more without a cyc call; model shifts are not needed here

      // R3: hold code with noise on the coefficient ports
      req = "R3";
      cyc(0, 0, 0, 0, 0, 0, 0);
      repeat (300) rand_cyc(0);

      // R5/R10: write a random column on many edges while data streams
      req = "R5/R10";
      for (int i = 0; i < 800; i++) rand_cyc(nextr() & 3);

      // R8: every product +2048, sum 6144 wraps to -2048
      req = "R8";
      cyc(0, 0, 0, 1, -512, -512, -512);
      cyc(0, 0, 0, 2, -512, -512, -512);
      cyc(0, 0, 0, 3, -512, -512, -512);
      repeat (6) cyc(-2048, -2048, -2048, 0, 0, 0, 0);
      chk("R8", "x wrap", sx(int'(x), DW), -2048);

      // R6: single impulse through random coefficients
      req = "R6";
      rand_cyc(1); rand_cyc(2); rand_cyc(3);
      repeat (5) cyc(0, 0, 0, 0, 0, 0, 0);
      cyc(1000, -1000, 777, 0, 0, 0, 0);
      repeat (8) cyc(0, 0, 0, 0, 0, 0, 0);

      // R9: reset in the middle of a stream
      req = "R9";
      repeat (10) rand_cyc(nextr() & 3);
      rst = 1'b1;
      rand_cyc(2);
      rst = 1'b0;
      repeat (8) rand_cyc(0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule